// File: doc/BRIEF.md
# 1-Wire Bus Master

This block runs a single open-drain 1-Wire line for a host that reaches it through a small two-word register window. The first word is a control word. It holds the enable, a self-clearing flush bit and the time-base settings, and it reports busy, the synchronised line level and the queue status. The second word carries commands and data. A write there puts a 2-bit command and an 8-bit payload into a command queue. A read returns the last received byte and the result of the last presence check.

The engine takes commands from the queue one at a time. A command is a reset with presence detect, one bit time slot, or eight slots for a whole byte. All slot timing is counted in base ticks. One tick lasts `(divider+1) * 2^(select+1)` clock cycles.

A byte goes out least significant bit first. The level sampled in each slot moves into the top of the shift register. The host reads by sending ones, so the master only releases the line. For a single bit, the host writes a byte filled with that bit, and the result appears in data bit 7. Address search and CRC work are left to software.

Top module: `owm_master`

## Requirements
- R1: After reset the control word reads 0x40008000: sense (bit 30) is 1, the depth field (bits 18:15) holds FIFO_LOG2 = 1, and every other bit is 0. The data word reads 0, and the line is released.
- R2: The control word layout is as follows. Enable is bit 0. Flush is bit 1, and it always reads 0. The tick select is bits 3:2 and the divider is bits 11:4; both read back as written. Bit 28 is queue full, bit 29 is received data waiting, bit 30 is line sense and bit 31 is busy.
- R3: One tick is `(div+1)<<(sel+1)` clocks. A bit slot whose transmit bit is 1 drives the line low for exactly 1 tick. A slot whose transmit bit is 0 drives low for exactly 6 ticks. Slots start every 8 ticks.
- R4: A reset command (data-word bits 9:8 = 11) drives low for exactly 48 ticks. It samples the line at the end of tick 57 and writes data-word bit 10 as 1 when the line was low, else 0. It does not set received-data-waiting.
- R5: A byte command (bits 9:8 = 10) sends data bits 7:0 in eight slots, bit 0 first.
- R6: At the end of each slot, the level sampled at the end of tick 2 is shifted into bit 7 and the register shifts right. A bit command (bits 9:8 = 01) therefore leaves its result in data bit 7, with the payload's bits 7:1 below it.
- R7: Every bit or byte command sets control bit 29 when it completes. A read of the data word clears it.
- R8: The queue holds 2 commands. A command written while it is full is dropped, and bit 28 is set while it is full.
- R9: Busy (bit 31) is 1 while the queue holds a command or the engine is running.
- R10: Writing enable = 0 releases the line within two clocks, ends the running command and empties the queue.
- R11: Writing the flush bit empties the queue, but the command that is already running completes.
- R12: A command word with bits 9:8 = 00 is not queued. A command written while the block is disabled is not queued.
- R13: Bit 30 shows the line level through a two-flop synchroniser; it reads 0 while the line is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears bit 29 on a data-word read) |
| regAddr | input | 1 | 0 = control word, 1 = command/data word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the addressed word |
| busIn | input | 1 | Level sensed on the 1-Wire line |
| busDriveLow | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
The embedded properties watch the following on every cycle: the tick is never asserted on two cycles in a row, the queue never counts past its depth, received data is flagged right after each transfer completes, and the line is released once the block is disabled. The exact low widths and slot spacing are checked only by the bench's scenarios, as are bit ordering, the values of received bytes, presence detection, dropping commands when the queue is full, and the difference between a flush and a disable. The bench sweeps every tick select against several divider values and models a responding slave on the line.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_BIT   = 2'b01,
    CMD_BYTE  = 2'b10,
    CMD_RESET = 2'b11
  } owCmdE;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic run;       // engine active, tick generator free-running
    logic pop;       // take head entry, load shift register
    logic sample;    // capture line level for this slot
    logic shift;     // end of slot: shift sampled bit in at the top
    logic writeRx;   // last slot done: publish received byte
    logic presence;  // presence sample point of a reset
  } owStrobeS;

  localparam int T_RST_LOW     = 48;
  localparam int T_RST_SAMPLE  = 57;
  localparam int T_RST_END     = 96;
  localparam int T_SLOT_LOW1   = 1;
  localparam int T_SLOT_LOW0   = 6;
  localparam int T_SLOT_SAMPLE = 2;
  localparam int T_SLOT_END    = 8;

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int FIFO_LOG2 = 1,
  parameter int DIV_W     = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic        regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        busIn,
  input  logic        engineActive,
  input  owStrobeS    st,
  output logic        enable,
  output logic        tick,
  output logic        fifoEmpty,
  output owCmdE       headCmd,
  output logic        txBit,
  output logic        busSync
);

  localparam int DEPTH  = 1 << FIFO_LOG2;
  localparam int CNT_W  = FIFO_LOG2 + 1;
  localparam int PRE_W  = DIV_W + 5;
  localparam int ENTRY_W = 10;

  logic             enableR;
  logic [1:0]       prescSel;
  logic [DIV_W-1:0] clkDiv;
  logic             ctrlWr, dcmdWr, clearPulse, flush, push, full;
  logic             unusedBits;

  assign unusedBits = ^regWdata[31:12];
  assign ctrlWr     = regWe && !regAddr;
  assign dcmdWr     = regWe && regAddr;
  assign clearPulse = ctrlWr && regWdata[1];
  assign flush      = clearPulse || !enableR;
  assign enable     = enableR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR  <= 1'b0;
      prescSel <= '0;
      clkDiv   <= '0;
    end else if (ctrlWr) begin
      enableR  <= regWdata[0];
      prescSel <= regWdata[3:2];
      clkDiv   <= regWdata[4 +: DIV_W];
    end
  end

  // two-flop synchroniser, idle line reads high
  logic [1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], busIn};
  end
  assign busSync = syncQ[1];

  // base tick: restarts whenever the engine goes idle
  logic [PRE_W-1:0] preCnt, tickLimit;
  logic [2:0]       shAmt;
  assign shAmt     = {1'b0, prescSel} + 3'd1;
  assign tickLimit = (({{(PRE_W-DIV_W){1'b0}}, clkDiv} + PRE_W'(1)) << shAmt) - PRE_W'(1);
  assign tick      = st.run && (preCnt == tickLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!st.run || tick) preCnt <= '0;
    else                      preCnt <= preCnt + PRE_W'(1);
  end

  // command queue
  logic [ENTRY_W-1:0]   mem [DEPTH];
  logic [FIFO_LOG2-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]     fifoCnt;

  assign full      = (fifoCnt == CNT_W'(DEPTH));
  assign fifoEmpty = (fifoCnt == '0);
  assign push      = dcmdWr && !flush && !full && (regWdata[9:8] != CMD_NOP);
  assign headCmd   = owCmdE'(mem[rdPtr][9:8]);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= regWdata[ENTRY_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fifoCnt <= '0;
    end else if (flush) begin
      wrPtr <= '0; rdPtr <= '0; fifoCnt <= '0;
    end else begin
      if (push)   wrPtr <= wrPtr + FIFO_LOG2'(1);
      if (st.pop) rdPtr <= rdPtr + FIFO_LOG2'(1);
      fifoCnt <= fifoCnt + CNT_W'(push) - CNT_W'(st.pop);
    end
  end

  // shift register and results
  logic [7:0] shReg, shNext, rxData;
  logic       sampleBit, rxAvail, presenceR;
  assign shNext = {sampleBit, shReg[7:1]};
  assign txBit  = shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0; sampleBit <= 1'b1; rxData <= '0; rxAvail <= 1'b0; presenceR <= 1'b0;
    end else begin
      if (st.pop)        shReg <= mem[rdPtr][7:0];
      else if (st.shift) shReg <= shNext;
      if (st.sample)     sampleBit <= busSync;
      if (st.presence)   presenceR <= !busSync;
      if (st.writeRx)    rxData <= shNext;
      if (st.writeRx)                        rxAvail <= 1'b1;
      else if ((regRe && regAddr) || clearPulse) rxAvail <= 1'b0;
    end
  end

  always_comb begin
    if (regAddr)
      regRdata = {21'd0, presenceR, 2'd0, rxData};
    else
      regRdata = {engineActive || !fifoEmpty, busSync, rxAvail, full, 9'd0,
                  4'(FIFO_LOG2), 3'd0, clkDiv, prescSel, 1'b0, enableR};
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_W'(DEPTH));
  p_rx_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.writeRx |=> rxAvail);

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
#(
  parameter int RST_LOW     = T_RST_LOW,
  parameter int RST_SAMPLE  = T_RST_SAMPLE,
  parameter int RST_END     = T_RST_END,
  parameter int SLOT_LOW1   = T_SLOT_LOW1,
  parameter int SLOT_LOW0   = T_SLOT_LOW0,
  parameter int SLOT_SAMPLE = T_SLOT_SAMPLE,
  parameter int SLOT_END    = T_SLOT_END
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     tick,
  input  logic     fifoEmpty,
  input  owCmdE    headCmd,
  input  logic     txBit,
  output owStrobeS st,
  output logic     engineActive,
  output logic     busDriveLow
);

  localparam int TICK_W = $clog2(RST_END);

  typedef enum logic [1:0] {S_IDLE, S_RESET, S_SLOT} stateE;

  stateE             state;
  logic [TICK_W-1:0] tickCnt, lowLen;
  logic [2:0]        bitIdx;
  logic              byteOp, start, slotEnd, lastSlot;

  assign start    = (state == S_IDLE) && enable && !fifoEmpty;
  assign slotEnd  = (state == S_SLOT) && tick && (tickCnt == TICK_W'(SLOT_END - 1));
  assign lastSlot = !byteOp || (bitIdx == 3'd7);

  always_comb begin
    st          = '0;
    st.run      = (state != S_IDLE);
    st.pop      = start;
    st.sample   = enable && (state == S_SLOT) && tick && (tickCnt == TICK_W'(SLOT_SAMPLE));
    st.shift    = enable && slotEnd;
    st.writeRx  = enable && slotEnd && lastSlot;
    st.presence = enable && (state == S_RESET) && tick && (tickCnt == TICK_W'(RST_SAMPLE));
  end

  assign lowLen       = (state == S_RESET) ? TICK_W'(RST_LOW)
                      : (txBit ? TICK_W'(SLOT_LOW1) : TICK_W'(SLOT_LOW0));
  assign busDriveLow  = (state != S_IDLE) && (tickCnt < lowLen);
  assign engineActive = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; tickCnt <= '0; bitIdx <= '0; byteOp <= 1'b0;
    end else if (!enable) begin
      state <= S_IDLE; tickCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= (headCmd == CMD_RESET) ? S_RESET : S_SLOT;
          byteOp  <= (headCmd == CMD_BYTE);
          bitIdx  <= '0;
          tickCnt <= '0;
        end
        S_RESET: if (tick) begin
          if (tickCnt == TICK_W'(RST_END - 1)) begin
            state <= S_IDLE; tickCnt <= '0;
          end else tickCnt <= tickCnt + TICK_W'(1);
        end
        S_SLOT: if (tick) begin
          if (slotEnd) begin
            tickCnt <= '0;
            if (lastSlot) state <= S_IDLE;
            else          bitIdx <= bitIdx + 3'd1;
          end else tickCnt <= tickCnt + TICK_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |=> !busDriveLow);
  p_reset_no_rx_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RESET) |-> !st.writeRx && !st.shift);

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int FIFO_LOG2 = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regRe,
  input  logic        regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        busIn,
  output logic        busDriveLow
);

  owStrobeS st;
  owCmdE    headCmd;
  logic     enable, tick, fifoEmpty, txBit, busSync, engineActive;

  owm_datapath #(.FIFO_LOG2(FIFO_LOG2), .DIV_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busIn(busIn),
    .engineActive(engineActive), .st(st), .enable(enable), .tick(tick),
    .fifoEmpty(fifoEmpty), .headCmd(headCmd), .txBit(txBit), .busSync(busSync)
  );

  owm_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .fifoEmpty(fifoEmpty),
    .headCmd(headCmd), .txBit(txBit), .st(st), .engineActive(engineActive),
    .busDriveLow(busDriveLow)
  );

  p_sense_low_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!busIn && $past(!busIn) && $past(!busIn, 2)) |-> !busSync);

endmodule

// File: tb/tb_owm_master.sv
module tb_owm_master;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, regWe, regRe, regAddr;
  logic [31:0] regWdata, regRdata;
  logic        busIn, busDriveLow;
  logic        slaveBitLow = 1'b0, slavePresLow = 1'b0;

  assign busIn = !(busDriveLow || slaveBitLow || slavePresLow);

  owm_master dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busIn(busIn), .busDriveLow(busDriveLow)
  );

  int checks = 0, fails = 0;
  int cycleNo = 0;
  int pulseCount = 0;
  int curP = 2;
  int respBase = 0;
  int holdCnt = 0;
  logic [7:0] respBits = 8'hFF;
  bit   slaveBitMode = 1'b0;
  logic prevDrv = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cycleNo <= cycleNo + 1;

  // slave model: answers read slots by holding the line low for 5 ticks
  always @(negedge clk) begin
    prevDrv <= busDriveLow;
    if (busDriveLow && !prevDrv) begin
      pulseCount <= pulseCount + 1;
      if (slaveBitMode && !respBits[(pulseCount - respBase) & 7]) begin
        slaveBitLow <= 1'b1;
        holdCnt     <= 1;
      end
    end else if (holdCnt != 0) begin
      if (holdCnt >= 5 * curP) begin
        slaveBitLow <= 1'b0;
        holdCnt     <= 0;
      end else holdCnt <= holdCnt + 1;
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input bit clr, input int sel, input int div);
    return 32'(en) | (32'(clr) << 1) | (32'(sel) << 2) | (32'(div) << 4);
  endfunction

  task automatic writeReg(input logic a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [31:0] d);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    do readReg(1'b0, v); while (v[31]);
  endtask

  task automatic measureLow(output int len, output int startCyc);
    while (!busDriveLow) @(negedge clk);
    startCyc = cycleNo;
    len = 0;
    while (busDriveLow) begin len++; @(negedge clk); end
  endtask

  task automatic presenceSlave(input bit respond);
    while (!busDriveLow) @(negedge clk);
    while (busDriveLow) @(negedge clk);
    repeat (4 * curP) @(negedge clk);
    slavePresLow = respond;
    repeat (20 * curP) @(negedge clk);
    slavePresLow = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int len, st0, prevSt, base, p;
    regWe = 0; regRe = 0; regAddr = 0; regWdata = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(1'b0, v); checkEq("R1 ctrl after reset", v, 32'h4000_8000);
    readReg(1'b1, v); checkEq("R1 data after reset", v, 32'h0);
    checkEq("R1 line released", 32'(busDriveLow), 32'h0);

    // R2 field readback, flush reads 0
    writeReg(1'b0, ctrlWord(1, 1, 2, 8'h5A));
    readReg(1'b0, v); checkEq("R2 ctrl readback", v & 32'hFFF, ctrlWord(1, 0, 2, 8'h5A));

    // R3 sweep of tick select and divider, R6 single-bit results
    for (int sel = 0; sel < 4; sel++) begin
      for (int div = 0; div < 3; div++) begin
        p = (div + 1) << (sel + 1);
        curP = p;
        writeReg(1'b0, ctrlWord(1, 0, sel, div));
        writeReg(1'b1, 32'h100);
        measureLow(len, st0);
        checkEq($sformatf("R3 write-0 low sel%0d div%0d", sel, div), 32'(len), 32'(6 * p));
        waitIdle();
        readReg(1'b1, v); checkEq("R6 bit write-0 result", v & 32'hFF, 32'h00);
        writeReg(1'b1, 32'h1FF);
        measureLow(len, st0);
        checkEq($sformatf("R3 write-1 low sel%0d div%0d", sel, div), 32'(len), 32'(p));
        waitIdle();
        readReg(1'b1, v); checkEq("R6 bit write-1 result", v & 32'hFF, 32'hFF);
      end
    end

    curP = 2;
    writeReg(1'b0, ctrlWord(1, 0, 0, 0));

    // R5 LSB-first byte, R3 slot spacing
    writeReg(1'b1, 32'h2A5);
    prevSt = 0;
    for (int k = 0; k < 8; k++) begin
      measureLow(len, st0);
      checkEq($sformatf("R5 byte slot %0d low", k), 32'(len), ((8'hA5 >> k) & 1) ? 32'd2 : 32'd12);
      if (k > 0) checkEq("R3 slot spacing", 32'(st0 - prevSt), 32'd16);
      prevSt = st0;
    end
    waitIdle();
    readReg(1'b0, v); checkEq("R7 rx flag set", 32'(v[29]), 32'd1);
    readReg(1'b1, v); checkEq("R6 byte echo", v & 32'hFF, 32'hA5);
    readReg(1'b0, v); checkEq("R7 rx flag cleared", 32'(v[29]), 32'd0);

    // R6 slave-driven byte read
    respBase = pulseCount; respBits = 8'h3C; slaveBitMode = 1'b1;
    writeReg(1'b1, 32'h2FF);
    waitIdle();
    readReg(1'b1, v); checkEq("R6 byte read from slave", v & 32'hFF, 32'h3C);
    respBase = pulseCount; respBits = 8'h00;
    writeReg(1'b1, 32'h1FF);
    waitIdle();
    slaveBitMode = 1'b0;
    readReg(1'b1, v); checkEq("R6 bit read 0 lands in bit 7", v & 32'hFF, 32'h7F);

    // R4 reset without then with presence; R13 sense
    writeReg(1'b1, 32'h300);
    measureLow(len, st0);
    checkEq("R4 reset low width", 32'(len), 32'd96);
    waitIdle();
    readReg(1'b0, v); checkEq("R4 reset leaves rx flag", 32'(v[29]), 32'd0);
    readReg(1'b1, v); checkEq("R4 no presence", 32'(v[10]), 32'd0);
    writeReg(1'b1, 32'h300);
    presenceSlave(1'b1);
    waitIdle();
    readReg(1'b1, v); checkEq("R4 presence seen", 32'(v[10]), 32'd1);
    writeReg(1'b1, 32'h300);
    while (!busDriveLow) @(negedge clk);
    repeat (4) @(negedge clk);
    readReg(1'b0, v); checkEq("R13 sense low", 32'(v[30]), 32'd0);
    waitIdle();
    readReg(1'b0, v); checkEq("R13 sense high", 32'(v[30]), 32'd1);

    // R8 queue full drop, R9 busy
    base = pulseCount;
    writeReg(1'b1, 32'h2FF);
    writeReg(1'b1, 32'h2FF);
    writeReg(1'b1, 32'h2FF);
    writeReg(1'b1, 32'h2FF);
    readReg(1'b0, v);
    checkEq("R8 full flag", 32'(v[28]), 32'd1);
    checkEq("R9 busy while queued", 32'(v[31]), 32'd1);
    waitIdle();
    checkEq("R8 fourth command dropped", 32'(pulseCount - base), 32'd24);
    readReg(1'b1, v);

    // R11 flush keeps the running command
    base = pulseCount;
    writeReg(1'b1, 32'h200);
    writeReg(1'b1, 32'h200);
    writeReg(1'b1, 32'h200);
    writeReg(1'b0, ctrlWord(1, 1, 0, 0));
    waitIdle();
    checkEq("R11 only running byte completes", 32'(pulseCount - base), 32'd8);
    readReg(1'b0, v); checkEq("R2 flush self-clears", v & 32'h3, 32'h1);
    readReg(1'b1, v);

    // R10 disable aborts and empties queue
    writeReg(1'b1, 32'h300);
    while (!busDriveLow) @(negedge clk);
    repeat (5) @(negedge clk);
    writeReg(1'b1, 32'h2FF);
    writeReg(1'b0, 32'h0);
    @(negedge clk);
    checkEq("R10 line released", 32'(busDriveLow), 32'd0);
    readReg(1'b0, v); checkEq("R10 not busy", 32'(v[31]), 32'd0);

    // R12 disabled writes and NOP ignored
    writeReg(1'b1, 32'h2FF);
    readReg(1'b0, v); checkEq("R12 disabled write ignored", 32'(v[31]), 32'd0);
    base = pulseCount;
    writeReg(1'b0, ctrlWord(1, 0, 0, 0));
    writeReg(1'b1, 32'h0FF);
    readReg(1'b0, v); checkEq("R12 NOP not queued", 32'(v[31]), 32'd0);
    repeat (100) @(negedge clk);
    checkEq("R10 queue flushed on disable", 32'(pulseCount - base), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule